// File: doc/BRIEF.md
# DMA Channel Interrupt and Loop Control Bank

This block is the shared control register bank that sits beside a group of DMA channel engines. Each channel reports the end of a transfer, or the end of a half-buffer when it loops, by pulsing a done line. The bank latches these pulses as pending flags and masks them with per-channel enables. It folds them into a single registered interrupt line for the processor.

Software reaches the bank through a plain memory-mapped register port: address, write enable, write data and combinational read data. Pending flags are cleared by writing ones. Enable and loop state can be changed with an ordinary read-modify-write of the main register, or per channel with no read through a dedicated clear alias that drops only the bits written as one.

A channel keeps looping only while both of its two loop bits are set. Software pauses a circular transfer by dropping those bits and resumes it by setting them again, with no other channel state touched. A separate write-only address issues one-cycle stop requests to chosen channels.

Top module: `dmaIrqLoopBank`

## Requirements
- R1: After reset the pending, enable and loop registers all read zero, and irqOut, chanLoop and chanStop are all low.
- R2: A one-cycle high on chanDone[n] sets pending bit n of the register at offset 0x144 (bit n = channel n). Writing that offset clears each pending bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R3: If a pending-clear write and a chanDone pulse hit the same bit in the same cycle, the bit is set after that cycle.
- R4: The enable register at offset 0x148 (bit n = channel n) takes the written value and reads it back. A write to offset 0x14C clears each enable bit written 1 and leaves the others unchanged.
- R5: The loop register at offset 0x150 keeps channel n's bits at positions n and n+16, and all other positions read zero. chanLoop[n] is high exactly when both bits are set.
- R6: A write to offset 0x15C clears each loop bit written 1 and leaves the others unchanged. Writing the cleared bits again at 0x150 brings chanLoop[n] back, and the enable and pending state are not changed by either step.
- R7: Writing offset 0x140 with bit n set drives chanStop[n] high for exactly the one cycle after the write. The offset reads zero and holds no state.
- R8: irqOut is the OR over all channels of pending AND enable, registered once. It rises one cycle after the first such pair appears and falls one cycle after the last one goes away.
- R9: Reading 0x14C returns the enable register, and reading 0x15C returns the loop register. Any other unmapped offset reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | ADDR_W | Register byte offset |
| regWe | input | 1 | Write strobe for one cycle |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| chanDone | input | NUM_CH | Per-channel completion pulses |
| irqOut | output | 1 | Combined registered interrupt |
| chanLoop | output | NUM_CH | Per-channel loop enable (both loop bits set) |
| chanStop | output | NUM_CH | Per-channel one-cycle stop request |

## Verification
The assertions check on every cycle that a pending bit set by a done pulse survives a same-cycle clear, and that a pending bit only falls after a write to the pending offset. They also check that enable bits and loop outputs only rise after a write to their main register, that stop requests only follow a write to the stop offset, and that the interrupt tracks the masked pending state one cycle late. The alias read values, the unmapped offsets being ignored, the pause and resume sequence, and each channel's bit position can only be shown by the bench's per-channel sweeps and scenarios.

// File: rtl/dmaBankPkg.sv
package dmaBankPkg;
  localparam int DATA_W      = 32;
  localparam int LOOP_HI_OFS = 16;

  localparam logic [15:0] OFS_STOP    = 16'h0140;
  localparam logic [15:0] OFS_PEND    = 16'h0144;
  localparam logic [15:0] OFS_EN      = 16'h0148;
  localparam logic [15:0] OFS_EN_CLR  = 16'h014C;
  localparam logic [15:0] OFS_LOOP    = 16'h0150;
  localparam logic [15:0] OFS_LOOP_CLR = 16'h015C;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_PEND = 2'd1,
    RD_EN   = 2'd2,
    RD_LOOP = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrPend;
    logic   wrEn;
    logic   clrEn;
    logic   wrLoop;
    logic   clrLoop;
    logic   wrStop;
    rdSel_e rdSel;
  } bankStrobe_t;
endpackage

// File: rtl/dmaBankDecode.sv
module dmaBankDecode
  import dmaBankPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output bankStrobe_t       strobe
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [15:0] ofs);
    return a == ofs[ADDR_W-1:0];
  endfunction

  logic isStop, isPend, isEn, isEnClr, isLoop, isLoopClr;

  always_comb begin
    isStop    = hit(regAddr, OFS_STOP);
    isPend    = hit(regAddr, OFS_PEND);
    isEn      = hit(regAddr, OFS_EN);
    isEnClr   = hit(regAddr, OFS_EN_CLR);
    isLoop    = hit(regAddr, OFS_LOOP);
    isLoopClr = hit(regAddr, OFS_LOOP_CLR);

    strobe.wrStop  = regWe & isStop;
    strobe.wrPend  = regWe & isPend;
    strobe.wrEn    = regWe & isEn;
    strobe.clrEn   = regWe & isEnClr;
    strobe.wrLoop  = regWe & isLoop;
    strobe.clrLoop = regWe & isLoopClr;

    if (isPend)                  strobe.rdSel = RD_PEND;
    else if (isEn || isEnClr)    strobe.rdSel = RD_EN;
    else if (isLoop || isLoopClr) strobe.rdSel = RD_LOOP;
    else                         strobe.rdSel = RD_ZERO;
  end
endmodule

// File: rtl/dmaBankRegs.sv
module dmaBankRegs
  import dmaBankPkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  bankStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] chanDone,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic [NUM_CH-1:0] chanLoop,
  output logic [NUM_CH-1:0] chanStop,
  output logic [NUM_CH-1:0] pendVec,
  output logic [NUM_CH-1:0] enVec
);
  logic [NUM_CH-1:0] wrBits;
  logic [NUM_CH-1:0] wrBitsHi;
  logic [NUM_CH-1:0] pendQ, enQ, loopLoQ, loopHiQ, stopQ;
  logic              irqQ;
  logic [NUM_CH-1:0] pendClr, pendD, enD, loopLoD, loopHiD;

  assign wrBits   = wrData[NUM_CH-1:0];
  assign wrBitsHi = wrData[LOOP_HI_OFS +: NUM_CH];

  always_comb begin
    pendClr = strobe.wrPend ? wrBits : '0;
    pendD   = (pendQ & ~pendClr) | chanDone;

    enD = enQ;
    if (strobe.wrEn)       enD = wrBits;
    else if (strobe.clrEn) enD = enQ & ~wrBits;

    loopLoD = loopLoQ;
    loopHiD = loopHiQ;
    if (strobe.wrLoop) begin
      loopLoD = wrBits;
      loopHiD = wrBitsHi;
    end else if (strobe.clrLoop) begin
      loopLoD = loopLoQ & ~wrBits;
      loopHiD = loopHiQ & ~wrBitsHi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ   <= '0;
      enQ     <= '0;
      loopLoQ <= '0;
      loopHiQ <= '0;
      stopQ   <= '0;
      irqQ    <= 1'b0;
    end else begin
      pendQ   <= pendD;
      enQ     <= enD;
      loopLoQ <= loopLoD;
      loopHiQ <= loopHiD;
      stopQ   <= strobe.wrStop ? wrBits : '0;
      irqQ    <= |(pendQ & enQ);
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_loopPair
    assign chanLoop[ch] = loopLoQ[ch] & loopHiQ[ch];
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      RD_PEND: rdData[NUM_CH-1:0] = pendQ;
      RD_EN:   rdData[NUM_CH-1:0] = enQ;
      RD_LOOP: begin
        rdData[NUM_CH-1:0]             = loopLoQ;
        rdData[LOOP_HI_OFS +: NUM_CH]  = loopHiQ;
      end
      default: rdData = '0;
    endcase
  end

  assign irqOut   = irqQ;
  assign chanStop = stopQ;
  assign pendVec  = pendQ;
  assign enVec    = enQ;
endmodule

// File: rtl/dmaIrqLoopBank.sv
module dmaIrqLoopBank
  import dmaBankPkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [NUM_CH-1:0] chanDone,
  output logic              irqOut,
  output logic [NUM_CH-1:0] chanLoop,
  output logic [NUM_CH-1:0] chanStop
);
  initial begin
    if (NUM_CH < 1 || NUM_CH > LOOP_HI_OFS) $error("NUM_CH must be 1..16");
    if (ADDR_W < 9) $error("ADDR_W too small for the register offsets");
  end

  bankStrobe_t       strobe;
  logic [NUM_CH-1:0] pendVec;
  logic [NUM_CH-1:0] enVec;

  dmaBankDecode #(.ADDR_W(ADDR_W)) u_decode (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strobe  (strobe)
  );

  dmaBankRegs #(.NUM_CH(NUM_CH)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .wrData   (regWdata),
    .chanDone (chanDone),
    .rdData   (regRdata),
    .irqOut   (irqOut),
    .chanLoop (chanLoop),
    .chanStop (chanStop),
    .pendVec  (pendVec),
    .enVec    (enVec)
  );
endmodule

// File: rtl/dmaBankChecker.sv
module dmaBankChecker
  import dmaBankPkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [NUM_CH-1:0] chanDone,
  input logic              irqOut,
  input logic [NUM_CH-1:0] chanLoop,
  input logic [NUM_CH-1:0] chanStop,
  input logic [NUM_CH-1:0] pendVec,
  input logic [NUM_CH-1:0] enVec
);
  logic wrPendOfs, wrEnOfs, wrLoopOfs, wrStopOfs;
  assign wrPendOfs = regWe && regAddr == OFS_PEND[ADDR_W-1:0];
  assign wrEnOfs   = regWe && regAddr == OFS_EN[ADDR_W-1:0];
  assign wrLoopOfs = regWe && regAddr == OFS_LOOP[ADDR_W-1:0];
  assign wrStopOfs = regWe && regAddr == OFS_STOP[ADDR_W-1:0];

  // R3: a done pulse always leaves its bit set, even against a clear
  a_r3_done_wins: assert property (@(posedge clk) disable iff (rst)
    (chanDone != '0) |=> ((pendVec & $past(chanDone)) == $past(chanDone)));

  // R2: pending bits fall only after a write to the pending offset
  a_r2_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    ((~pendVec & $past(pendVec)) != '0) |-> $past(wrPendOfs));

  // R4: enable bits rise only after a write to the enable offset
  a_r4_enable_rise: assert property (@(posedge clk) disable iff (rst)
    ((enVec & ~$past(enVec)) != '0) |-> $past(wrEnOfs));

  // R5: a loop output rises only after a write to the loop offset
  a_r5_loop_rise: assert property (@(posedge clk) disable iff (rst)
    ((chanLoop & ~$past(chanLoop)) != '0) |-> $past(wrLoopOfs));

  // R7: stop requests only follow a stop write
  a_r7_stop_source: assert property (@(posedge clk) disable iff (rst)
    (chanStop != '0) |-> $past(wrStopOfs));

  // R8: interrupt tracks masked pending one cycle late
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irqOut == $past(|(pendVec & enVec))));
endmodule

bind dmaIrqLoopBank dmaBankChecker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .regAddr  (regAddr),
  .regWe    (regWe),
  .chanDone (chanDone),
  .irqOut   (irqOut),
  .chanLoop (chanLoop),
  .chanStop (chanStop),
  .pendVec  (pendVec),
  .enVec    (enVec)
);

// File: tb/test_dmaIrqLoopBank.sv
module test_dmaIrqLoopBank;
  localparam int NCH = 16;
  localparam int AW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] regAddr = '0;
  logic          regWe = 1'b0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [NCH-1:0] chanDone = '0;
  logic          irqOut;
  logic [NCH-1:0] chanLoop;
  logic [NCH-1:0] chanStop;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dmaIrqLoopBank #(.NUM_CH(NCH), .ADDR_W(AW)) i_dmaIrqLoopBank (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .chanDone(chanDone),
    .irqOut(irqOut), .chanLoop(chanLoop), .chanStop(chanStop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk);
    chanDone = m;
    @(negedge clk);
    chanDone = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(12'h144, v); check("R1 pend", v, 0);
    rd(12'h148, v); check("R1 enable", v, 0);
    rd(12'h150, v); check("R1 loop", v, 0);
    check("R1 outputs", {irqOut, chanLoop, chanStop}, 0);

    // R2 per-channel set and write-one clear
    for (int n = 0; n < NCH; n++) begin
      pulse(NCH'(1) << n);
      rd(12'h144, v); check("R2 set", v, 32'(1) << n);
      wr(12'h144, ~(32'(1) << n) & 32'hFFFF);
      rd(12'h144, v); check("R2 zeros ignored", v, 32'(1) << n);
      wr(12'h144, 32'(1) << n);
      rd(12'h144, v); check("R2 cleared", v, 0);
    end

    // R3 simultaneous clear and set
    pulse(16'hA5A5);
    @(negedge clk);
    regAddr = 12'h144; regWdata = 32'hFFFF; regWe = 1'b1; chanDone = 16'h0101;
    @(negedge clk);
    regWe = 1'b0; chanDone = '0;
    rd(12'h144, v); check("R3 set wins", v, 32'h0101);
    wr(12'h144, 32'hFFFF);

    // R4 enable sweep and clear alias
    for (int n = 0; n < NCH; n++) begin
      wr(12'h148, 32'hFFFF);
      wr(12'h14C, 32'(1) << n);
      rd(12'h148, v); check("R4 alias clear", v, 32'hFFFF & ~(32'(1) << n));
    end
    wr(12'h148, 32'h3C3C);
    rd(12'h148, v); check("R4 write", v, 32'h3C3C);
    rd(12'h14C, v); check("R9 enable alias read", v, 32'h3C3C);
    wr(12'h148, 0);

    // R5 loop pair per channel
    for (int n = 0; n < NCH; n++) begin
      wr(12'h150, 32'(1) << n);
      check("R5 low bit only", 32'(chanLoop), 0);
      wr(12'h150, 32'(1) << (n + 16));
      check("R5 high bit only", 32'(chanLoop), 0);
      wr(12'h150, (32'(1) << n) | (32'(1) << (n + 16)));
      check("R5 both bits", 32'(chanLoop), 32'(1) << n);
    end
    wr(12'h150, 32'hFFFF_FFFF);
    rd(12'h150, v); check("R5 readback", v, 32'hFFFF_FFFF);
    rd(12'h15C, v); check("R9 loop alias read", v, 32'hFFFF_FFFF);

    // R6 pause and resume
    wr(12'h148, 32'h0010);
    pulse(16'h0020);
    wr(12'h15C, 32'h0008_0008);
    check("R6 paused", 32'(chanLoop), 32'hFFF7);
    rd(12'h150, v); check("R6 loop after clear", v, 32'hFFF7_FFF7);
    rd(12'h148, v); check("R6 enable kept", v, 32'h0010);
    rd(12'h144, v); check("R6 pend kept", v, 32'h0020);
    wr(12'h150, 32'hFFFF_FFFF);
    check("R6 resumed", 32'(chanLoop), 32'hFFFF);
    wr(12'h15C, 32'h0000_0100);
    check("R6 half clear", 32'(chanLoop), 32'hFEFF);
    wr(12'h144, 32'hFFFF); wr(12'h148, 0); wr(12'h15C, 32'hFFFF_FFFF);

    // R7 stop per channel
    for (int n = 0; n < NCH; n++) begin
      wr(12'h140, 32'(1) << n);
      check("R7 stop high", 32'(chanStop), 32'(1) << n);
      @(negedge clk);
      check("R7 stop one cycle", 32'(chanStop), 0);
    end
    rd(12'h140, v); check("R7 stop reads zero", v, 0);

    // R8 interrupt latency and masking
    pulse(16'h0004);
    @(negedge clk);
    check("R8 masked", 32'(irqOut), 0);
    wr(12'h148, 32'h0004);
    check("R8 not yet", 32'(irqOut), 0);
    @(negedge clk);
    check("R8 raised", 32'(irqOut), 1);
    wr(12'h144, 32'h0004);
    check("R8 still high", 32'(irqOut), 1);
    @(negedge clk);
    check("R8 fallen", 32'(irqOut), 0);
    pulse(16'h0004);
    @(negedge clk);
    check("R8 again", 32'(irqOut), 1);
    wr(12'h14C, 32'h0004);
    @(negedge clk);
    check("R8 disabled", 32'(irqOut), 0);
    wr(12'h144, 32'hFFFF);

    // R9 unmapped offsets
    wr(12'h148, 32'h00F0);
    wr(12'h150, 32'h0001_0001);
    for (int a = 12'h100; a < 12'h180; a += 4) begin
      if (a == 12'h140 || a == 12'h144 || a == 12'h148 || a == 12'h14C ||
          a == 12'h150 || a == 12'h15C) continue;
      wr(AW'(a), 32'hFFFF_FFFF);
      rd(AW'(a), v); check("R9 unmapped reads zero", v, 0);
    end
    rd(12'h148, v); check("R9 enable untouched", v, 32'h00F0);
    rd(12'h150, v); check("R9 loop untouched", v, 32'h0001_0001);
    rd(12'h144, v); check("R9 pend untouched", v, 0);
    check("R9 no stop", 32'(chanStop), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule